// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into bytes. The line carries frames made of a low start bit, eight data bits sent least significant bit first, and a high stop bit. The receiver has no copy of the sender's clock. It runs from a local clock at sixteen times the bit rate. The falling edge that opens the start bit fixes the timing for the whole frame. Every later decision is made at the middle of a bit period, counted in oversample clocks from that edge.

The raw line first passes through a two-flop synchronizer. A falling edge on the synchronized line starts a half-bit wait. At the middle of the start bit the line is checked again, and a line that has gone back high is treated as noise. After a valid start, eight full-bit waits each shift one sample into a shift register. A last full-bit wait reaches the middle of the stop bit. There the byte is presented together with a one-clock strobe, and a low stop bit raises the framing-error flag. A new frame is not accepted until the line has been seen high after the stop sample.

Top module: `serial_rx16`

## Requirements
- R1: While and after reset (active-low `rst_n`), `rx_valid` is 0, `frame_err` is 0, `rx_byte` is 0x00 and `line_in` is idle high.
- R2: A frame of one low start bit, eight data bits (first bit sent goes to `rx_byte[0]`) and a stop bit produces exactly one `rx_valid` pulse, one clock wide. In that pulse `rx_byte` holds the eight data bits.
- R3: Count as edge 1 the first rising clock edge at which `line_in` is low at the start bit. `rx_valid` becomes high on edge 155, which includes two clocks of synchronizer delay.
- R4: Each data bit is taken from `line_in` as seen at oversample clock 8 of its 16-clock period, counting from 0. Line values at offsets 0–3 and 12–15 of a bit do not change the received byte.
- R5: A low pulse on `line_in` shorter than 8 clocks, followed by a high line, produces no `rx_valid` pulse. A correct frame that follows it is received normally.
- R6: The stop bit is sampled at offset 8 of its period. If it is low, `frame_err` is 1 during the `rx_valid` pulse and the byte is still delivered. If it is high, `frame_err` is 0.
- R7: `frame_err` and `rx_byte` change only at an `rx_valid` pulse and hold their values between pulses.
- R8: After the stop sample, the receiver accepts no new frame until the line has been seen high. A line held low after a low stop bit produces no further pulse.
- R9: Frames sent back to back, with a start bit directly after a 16-clock stop bit, are all received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16x the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Raw asynchronous serial line, idle high |
| rx_byte | output | 8 | Last received byte, LSB = first data bit |
| rx_valid | output | 1 | One-clock strobe at the stop-bit check |
| frame_err | output | 1 | Stop bit was low in the last frame |

## Verification
The hardest case to reach from the ports is a line whose level is only right near the middle of each bit. A receiver that samples early, late or more than once would still pass on clean frames. The bench therefore drives the inverse of each data bit during the first four and last four clocks of its period, for a sweep of byte values, and expects the intended byte back. Glitches on the start bit, of every length from 1 to 7 clocks, show that the mid-start check rejects them at the boundary. A low stop bit followed by a held-low line covers the re-arm path.

// File: rtl/serial_rx16_pkg.sv
// Shared types for the oversampling serial receiver.
package serial_rx16_pkg;

    // Receive sequencer states.
    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_REARM = 3'd4
    } rx_state_t;

endpackage

// File: rtl/rx_line_sync.sv
// rx_line_sync: brings the asynchronous serial line into the clock domain
// through a chain of STAGES flops and flags a high-to-low transition of the
// synchronized level. Assumes the line idles high; every flop resets to 1 so
// that reset release is never seen as an edge.
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_raw,
    output logic line_s,
    output logic line_fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer chain: stage 0 captures the raw line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q[0] <= line_raw;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign line_s    = chain_q[STAGES-1];
    assign line_fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rx_delay_cnt.sv
// rx_delay_cnt: loadable down-counter used to time half-bit and full-bit
// waits. A load takes priority; otherwise it decrements until it reaches
// zero and stays there. 'expired' is high while the count is zero.
module rx_delay_cnt #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             expired
);
    logic [WIDTH-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign count   = cnt_q;
    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rx_shift.sv
// rx_shift: serial-to-parallel register. Bits arrive least significant
// first, so each new sample enters at the top and the word moves right;
// after BITS shifts the first sample sits in bit 0.
module rx_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] word
);
    logic [BITS-1:0] word_q;

    // Shift one sample in when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)        word_q <= '0;
        else if (shift_en) word_q <= {bit_in, word_q[BITS-1:1]};
    end

    assign word = word_q;
endmodule

// File: rtl/serial_rx16.sv
// serial_rx16: asynchronous serial receiver clocked at OVERSAMPLE times the
// bit rate. A falling edge on the synchronized line starts a half-bit wait;
// the start bit is re-checked at its middle, then DATA_BITS samples are taken
// one bit period apart, and the stop bit is checked at its middle, where the
// byte, a one-clock strobe and the framing flag are updated. Assumes an idle-
// high line, LSB-first data, OVERSAMPLE even and DATA_BITS of at least 2.
module serial_rx16 #(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_BITS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_valid,
    output logic                 frame_err
);
    import serial_rx16_pkg::*;

    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [CNT_W-1:0] HALF_LOAD = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LOAD = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DATA_BITS - 1);

    rx_state_t            state_q, state_d;
    logic                 line_s, line_fall;
    logic                 cnt_load, cnt_expired;
    logic [CNT_W-1:0]     cnt_val, cnt_q;
    logic                 shift_en, take;
    logic [IDX_W-1:0]     idx_q;
    logic [DATA_BITS-1:0] word;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_raw  (line_in),
        .line_s    (line_s),
        .line_fall (line_fall)
    );

    rx_delay_cnt #(.WIDTH(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .count    (cnt_q),
        .expired  (cnt_expired)
    );

    rx_shift #(.BITS(DATA_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (line_s),
        .word     (word)
    );

    // Sequencer decisions: next state, delay loads, shift and capture.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = FULL_LOAD;
        shift_en = 1'b0;
        take     = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if (line_fall) begin
                    state_d  = RX_START;
                    cnt_load = 1'b1;
                    cnt_val  = HALF_LOAD;
                end
            end
            RX_START: begin
                if (cnt_expired) begin
                    if (!line_s) begin
                        state_d  = RX_DATA;
                        cnt_load = 1'b1;
                    end else begin
                        state_d  = RX_IDLE;
                    end
                end
            end
            RX_DATA: begin
                if (cnt_expired) begin
                    shift_en = 1'b1;
                    cnt_load = 1'b1;
                    if (idx_q == LAST_IDX) state_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (cnt_expired) begin
                    take    = 1'b1;
                    state_d = RX_REARM;
                end
            end
            RX_REARM: begin
                if (line_s) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Data-bit index: cleared at a valid start, advanced on every sample.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      idx_q <= '0;
        else if (state_q == RX_START)                    idx_q <= '0;
        else if (shift_en && idx_q != LAST_IDX)          idx_q <= idx_q + 1'b1;
    end

    // Output registers: byte, strobe and framing flag update at the stop check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            rx_valid <= take;
            if (take) begin
                rx_byte   <= word;
                frame_err <= ~line_s;
            end
        end
    end
endmodule

// File: rtl/serial_rx16_chk.sv
// serial_rx16_chk: temporal checks on the receiver, attached by bind.
module serial_rx16_chk #(
    parameter int DATA_BITS = 8,
    parameter int CNT_W     = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         line_s,
    input serial_rx16_pkg::rx_state_t   state,
    input logic [CNT_W-1:0]             cnt,
    input logic [DATA_BITS-1:0]         rx_byte,
    input logic                         rx_valid,
    input logic                         frame_err
);
    import serial_rx16_pkg::*;

    // R2: the strobe never lasts two clocks.
    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: the framing flag only moves with a strobe.
    p_err_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> frame_err == $past(frame_err) || $past(!rst_n));

    // R7: the byte only moves with a strobe.
    p_byte_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> rx_byte == $past(rx_byte) || $past(!rst_n));

    // R5: a high line at the start-bit middle returns to idle.
    p_false_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && cnt == '0 && line_s) |=> state == RX_IDLE);

    // R8: leaving the re-arm wait requires having seen the line high.
    p_rearm_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && $past(state) == RX_REARM) |-> $past(line_s));

    // R2: a strobe is always preceded by the stop state.
    p_valid_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(state) == RX_STOP);
endmodule

bind serial_rx16 serial_rx16_chk #(
    .DATA_BITS (DATA_BITS),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_s    (line_s),
    .state     (state_q),
    .cnt       (cnt_q),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .frame_err (frame_err)
);

// File: tb/serial_rx16_test.sv
// Self-checking bench: exhaustive byte sweep plus noise, glitch and break cases.
module serial_rx16_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       frame_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pulses = 0;
    int last_cyc = 0;
    logic [7:0] last_byte = 8'h00;
    logic       last_err = 1'b0;
    bit done = 1'b0;

    serial_rx16 uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .frame_err (frame_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: record every strobe away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            pulses    = pulses + 1;
            last_cyc  = cyc;
            last_byte = rx_byte;
            last_err  = frame_err;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_in = v;
        end
    endtask

    // One frame; noisy=1 inverts each data bit outside offsets 4..11.
    task automatic send_frame(input logic [7:0] d, input logic stop, input bit noisy,
                              output int t0);
        @(negedge clk);
        line_in = 1'b0;
        t0 = cyc;
        hold(1'b0, 15);
        for (int b = 0; b < 8; b++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                line_in = (noisy && (j < 4 || j > 11)) ? ~d[b] : d[b];
            end
        end
        hold(stop, 16);
    endtask

    task automatic frame_check(input logic [7:0] d, input logic stop, input bit noisy,
                               input string req);
        int p0;
        int t0;
        p0 = pulses;
        send_frame(d, stop, noisy, t0);
        check(pulses == p0 + 1, {req, " pulse count"}, pulses - p0, 1);
        check(last_byte == d, {req, " byte"}, last_byte, d);
        check(last_err == ~stop, {req, " frame_err"}, last_err, ~stop);
        check(last_cyc == t0 + 155, {req, " R3 latency"}, last_cyc - t0, 155);
    endtask

    initial begin
        int p0;
        int t0;
        hold(1'b1, 5);
        // R1: reset values
        check(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
        check(rx_byte == 8'h00, "R1 rx_byte", rx_byte, 0);
        @(negedge clk);
        rst_n = 1'b1;
        hold(1'b1, 20);
        check(pulses == 0, "R1 idle no strobe", pulses, 0);

        // R2 R3 R9: every byte value, frames back to back
        for (int v = 0; v < 256; v++) frame_check(8'(v), 1'b1, 1'b0, "R2 R9 sweep");

        // R4: noisy bit edges, value only right around the middle
        for (int v = 0; v < 256; v += 17) frame_check(8'(v), 1'b1, 1'b1, "R4 noisy");
        frame_check(8'h55, 1'b1, 1'b1, "R4 noisy alt");

        // R5: start glitches of 1..7 clocks
        for (int k = 1; k < 8; k++) begin
            p0 = pulses;
            hold(1'b0, k);
            hold(1'b1, 40);
            check(pulses == p0, "R5 glitch rejected", pulses - p0, 0);
        end
        frame_check(8'hA5, 1'b1, 1'b0, "R5 frame after glitch");

        // R6 R8: low stop bit, then line held low
        hold(1'b1, 10);
        frame_check(8'h3C, 1'b0, 1'b0, "R6 low stop");
        p0 = pulses;
        hold(1'b0, 300);
        check(pulses == p0, "R8 held low no frame", pulses - p0, 0);
        check(frame_err == 1'b1, "R7 err held", frame_err, 1);
        check(rx_byte == 8'h3C, "R7 byte held", rx_byte, 8'h3C);
        hold(1'b1, 20);
        frame_check(8'h5A, 1'b1, 1'b0, "R6 R8 after break");
        check(frame_err == 1'b0, "R7 err cleared", frame_err, 0);

        // R6: low stop with the line released right after
        send_frame(8'hC3, 1'b0, 1'b0, t0);
        check(last_err == 1'b1 && last_byte == 8'hC3, "R6 err with byte", last_byte, 8'hC3);
        hold(1'b1, 20);
        frame_check(8'h81, 1'b1, 1'b0, "R6 recovery");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int i = 0; i < 190000; i++) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule